// File: doc/BRIEF.md
# Self-Correcting Three-Stage Token Ring

This block is a synchronous three-stage ring that passes a single active bit from stage to stage to produce a repeating sequence of non-overlapping enables. The most significant stage holds the token at start-up and after reset. The token then moves one stage toward the least significant end on each enabled clock, and it wraps from the lowest stage back to the highest.

A plain shift ring keeps whatever bits it holds and repeats them forever. This block does not. A one-of-eight decode of the present value drives every next-state bit. Any pattern other than the three legal ones is replaced by the home value on the very next clock edge, whether or not advance is high. The all-zero pattern and the multi-bit patterns are treated the same way. A combinational flag tells the surrounding logic when the present value is not legal.

Top module: `heal_ring`

## Requirements
- R1: The legal values of `ringState` (bit 2 is the most significant) are 3'b100, 3'b010 and 3'b001. For each of them `illegal` is 0.
- R2: With `rst` low, `advance` high and a legal present value, the next edge moves 3'b100 to 3'b010, 3'b010 to 3'b001, and 3'b001 to 3'b100.
- R3: With `rst` low and an illegal present value, the next edge loads 3'b100, whatever the level of `advance`.
- R4: `illegal` is 1 in the same cycle, with no clock edge needed, whenever `ringState` is 3'b000, 3'b011, 3'b101, 3'b110 or 3'b111.
- R5: With `rst` high (synchronous, active high), the next edge loads 3'b100. This takes priority over both advance and recovery.
- R6: With `rst` low, `advance` low and a legal present value, `ringState` keeps its value across the edge.
- R7: Starting from any of the eight 3-bit values, one edge with `rst` low leaves `ringState` at a legal value.
- R8: With `advance` held high from 3'b100, the value comes back to 3'b100 after exactly three edges and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high, loads 3'b100 |
| advance | input | 1 | Moves the token one stage on the next edge when the present value is legal |
| ringState | output | 3 | Present ring value, one bit per stage |
| illegal | output | 1 | High while the present value is not one of the three legal codes |

## Verification
The bench corrupts the ring register between edges so that it starts from each of the eight codes, once with advance low and once with advance high. A design that waits for advance before it recovers would leave an illegal value in place while advance is low. A design that only checks the top bit would rotate 3'b110 or 3'b101 into another multi-bit pattern. Separate cases drive reset and advance together, where a wrong priority would rotate instead of homing, and count the wrap from the lowest stage to check the period of three. Random runs with a fixed seed then mix reset, advance and occasional corruption, and each edge is compared with a bench-side model of the next value.

// File: rtl/heal_ring_pkg.sv
package heal_ring_pkg;

  // Strobes from control to datapath; at most one is high in a cycle.
  typedef struct packed {
    logic loadHome;   // replace the value with the home code
    logic step;       // move the token one stage toward bit 0
  } ringCtrl_t;

endpackage

// File: rtl/heal_ring_dp.sv
module heal_ring_dp
  import heal_ring_pkg::*;
#(
  parameter int RING_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  ringCtrl_t               ctl,
  output logic [RING_W-1:0]       stateQ,
  output logic [(1<<RING_W)-1:0]  hotLines
);

  localparam int NCODE = 1 << RING_W;
  localparam logic [RING_W-1:0] HOME = RING_W'(1) << (RING_W - 1);

  logic [RING_W-1:0] rotNext;
  logic [RING_W-1:0] nextState;

  // One-of-NCODE decode of the present value.
  always_comb begin
    for (int k = 0; k < NCODE; k++) begin
      hotLines[k] = (stateQ == RING_W'(k));
    end
  end

  // Each stage takes the decode line of the code whose token sits one
  // stage above it; the lowest code wraps round to the top stage.
  generate
    for (genvar i = 0; i < RING_W - 1; i++) begin : g_stage
      assign rotNext[i] = hotLines[1 << (i + 1)];
    end
  endgenerate
  assign rotNext[RING_W-1] = hotLines[1];

  always_comb begin
    if (ctl.loadHome)  nextState = HOME;
    else if (ctl.step) nextState = rotNext;
    else               nextState = stateQ;
  end

  always_ff @(posedge clk) begin
    stateQ <= nextState;
  end

  // R2: a step rotates the present value one place toward bit 0
  a_r2_rotate : assert property (@(posedge clk) disable iff (rst)
    ctl.step |-> nextState == {stateQ[0], stateQ[RING_W-1:1]});

  // R6: with no strobe the value is kept
  a_r6_hold : assert property (@(posedge clk) disable iff (rst)
    (!ctl.loadHome && !ctl.step) |-> nextState == stateQ);

  // R7: whatever the present value, the next value is legal
  a_r7_next_legal : assert property (@(posedge clk) disable iff (rst)
    $onehot(nextState));

  // R5: reset loads the home value
  always_ff @(posedge clk) begin
    if (rst) begin
      a_r5_reset_home : assert (nextState == HOME);
    end
  end

endmodule

// File: rtl/heal_ring_ctrl.sv
module heal_ring_ctrl
  import heal_ring_pkg::*;
#(
  parameter int RING_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    advance,
  input  logic [(1<<RING_W)-1:0]  hotLines,
  output ringCtrl_t               ctl,
  output logic                    illegal
);

  logic [RING_W-1:0] legalLines;
  logic              legal;

  // A value is legal when the decode line of a single-bit code is high.
  generate
    for (genvar i = 0; i < RING_W; i++) begin : g_legal
      assign legalLines[i] = hotLines[1 << i];
    end
  endgenerate

  assign legal   = |legalLines;
  assign illegal = ~legal;

  always_comb begin
    ctl          = '0;
    ctl.loadHome = rst | illegal;
    ctl.step     = ~rst & legal & advance;
  end

  // R3: an illegal value always requests the home load
  a_r3_recover : assert property (@(posedge clk) disable iff (rst)
    illegal |-> (ctl.loadHome && !ctl.step));

  // R5: reset overrides advance
  always_ff @(posedge clk) begin
    if (rst) begin
      a_r5_reset_priority : assert (ctl.loadHome && !ctl.step);
    end
  end

  // R2: strobes never conflict
  a_r2_strobe_excl : assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.loadHome, ctl.step}));

  // R4: the decode always has exactly one active line
  a_r4_decode_onehot : assert property (@(posedge clk) disable iff (rst)
    $onehot(hotLines));

endmodule

// File: rtl/heal_ring.sv
module heal_ring
  import heal_ring_pkg::*;
#(
  parameter int RING_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  output logic [RING_W-1:0] ringState,
  output logic              illegal
);

  localparam int NCODE = 1 << RING_W;

  ringCtrl_t        ctl;
  logic [NCODE-1:0] hotLines;

  heal_ring_ctrl #(.RING_W(RING_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .advance  (advance),
    .hotLines (hotLines),
    .ctl      (ctl),
    .illegal  (illegal)
  );

  heal_ring_dp #(.RING_W(RING_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .stateQ   (ringState),
    .hotLines (hotLines)
  );

  // R1, R4: the flag is low exactly when one stage holds the token
  a_r4_flag : assert property (@(posedge clk) disable iff (rst)
    illegal == ($countones(ringState) != 1));

endmodule

// File: tb/tb_heal_ring.sv
module tb_heal_ring;

  logic       clk = 1'b0;
  logic       rst;
  logic       advance;
  logic [2:0] ringState;
  logic       illegal;

  int testsRun  = 0;
  int testsFail = 0;
  logic [2:0] model;

  heal_ring dut (
    .clk       (clk),
    .rst       (rst),
    .advance   (advance),
    .ringState (ringState),
    .illegal   (illegal)
  );

  always #5 clk = ~clk;

  function automatic logic isLegal(input logic [2:0] s);
    return (s == 3'b100) || (s == 3'b010) || (s == 3'b001);
  endfunction

  function automatic logic [2:0] expNext(input logic [2:0] s, input logic r,
                                          input logic a);
    if (r)           return 3'b100;
    if (!isLegal(s)) return 3'b100;
    if (!a)          return s;
    case (s)
      3'b100:  return 3'b010;
      3'b010:  return 3'b001;
      default: return 3'b100;
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] act,
                       input logic [2:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Put an arbitrary value into the ring register between edges.
  task automatic upset(input logic [2:0] v);
    force dut.u_dp.stateQ = v;
    release dut.u_dp.stateQ;
    model = v;
  endtask

  // One cycle: drive at the falling edge, check the flag, then the new value.
  task automatic cycle(input logic r, input logic a, input string req);
    rst     = r;
    advance = a;
    #1;
    check({req, " flag R4/R1"}, {2'b00, illegal}, {2'b00, ~isLegal(model)});
    @(posedge clk);
    #1;
    model = expNext(model, r, a);
    check(req, ringState, model);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    testsFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0001));
    rst = 1'b1; advance = 1'b0; model = 3'b100;
    @(negedge clk);
    cycle(1'b1, 1'b0, "R5 reset");
    check("R5 reset state", ringState, 3'b100);

    // R2 / R8: sequence and period of three
    cycle(1'b0, 1'b1, "R2 100->010");
    cycle(1'b0, 1'b1, "R2 010->001");
    cycle(1'b0, 1'b1, "R8 wrap 001->100");

    // R6: hold at each legal value
    for (int k = 0; k < 3; k++) begin
      cycle(1'b0, 1'b0, "R6 hold");
      cycle(1'b0, 1'b1, "R2 step");
    end

    // R5 priority over advance, from a non-home legal value
    cycle(1'b0, 1'b1, "R2 step");
    cycle(1'b1, 1'b1, "R5 reset beats advance");
    // R5 priority over recovery
    upset(3'b011);
    cycle(1'b1, 1'b1, "R5 reset from illegal");

    // R3 / R7: every starting code, advance low and high
    for (int a = 0; a < 2; a++) begin
      for (int v = 0; v < 8; v++) begin
        upset(3'(v));
        cycle(1'b0, 1'(a), isLegal(3'(v)) ? "R7 legal start" : "R3 recover");
        check("R7 legal after one edge", {2'b00, isLegal(ringState)}, 3'b001);
      end
    end

    // Random mix
    for (int n = 0; n < 2000; n++) begin
      if (($urandom % 8) == 0) upset(3'($urandom % 8));
      cycle((($urandom % 16) == 0), 1'($urandom % 2), "R2/R3/R5/R6 random");
    end

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFail);
    $finish;
  end

endmodule